// File: doc/BRIEF.md
# I2C Master Arbitration Loss Detector

This block sits beside an I2C master transmitter and watches for a lost arbitration. On every SCL rising edge it compares the bit the master wants to put on SDA with the level it actually samples on the line. If the master is releasing SDA (wants a 1) but another device is pulling the line low, then the master has lost the bus. The block sets a sticky lost flag and changes the mode bits it holds in the order the bus requires.

Transmit mode drops in the same update that records the loss, so the master stops driving data at once. Master mode is held until the byte in progress has finished, which lets the clock logic complete that byte. If the loss happens while the slave-address byte is being sent, the block raises an address-watch output for the rest of that byte. The surrounding logic uses it to compare its own address against the one the winning master sends. The mode bits are loaded from outside with a load strobe.

Top module: `i2c_arb_loss_det`

## Requirements
- R1: After reset, lost_o, mst_o, xmt_o and addr_watch_o are all 0.
- R2: When mode_ld_i is 1 in a cycle, mst_o and xmt_o take the values of mst_in_i and xmt_in_i in the next cycle.
- R3: A detection happens in a cycle where scl_rise_i=1, mst_o=1, xmt_o=1, want_sda_i=1 and sda_i=0. In the next cycle lost_o is 1 and xmt_o is 0, while mst_o stays 1.
- R4: A bit where want_sda_i=0, or where sda_i=1, never causes a detection, whatever the other inputs are.
- R5: There is no detection unless mst_o and xmt_o are both 1 and scl_rise_i is 1.
- R6: After a detection, mst_o stays 1 until the first byte_done_i strobe. It reads 0 from the cycle after that strobe. The same holds when the strobe arrives in the detecting cycle itself.
- R7: A byte_done_i strobe with no detection since the last mode load leaves mst_o unchanged.
- R8: lost_o stays at 1 until clr_i is strobed, and reads 0 in the cycle after the strobe. If a detection and clr_i occur in the same cycle, the detection wins.
- R9: A detection with addr_phase_i=1 sets addr_watch_o in the next cycle, and a byte_done_i strobe clears it. A detection with addr_phase_i=0 leaves addr_watch_o at 0.
- R10: If mode_ld_i coincides with a detection, the loaded values appear on mst_o and xmt_o and the pending master drop is cancelled, but lost_o still sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_ld_i | input | 1 | Load strobe for the mode bits |
| mst_in_i | input | 1 | Master-mode value to load |
| xmt_in_i | input | 1 | Transmit-mode value to load |
| want_sda_i | input | 1 | SDA level the master intends for the current bit |
| sda_i | input | 1 | Sampled SDA line level |
| scl_rise_i | input | 1 | One-cycle strobe on each SCL rising edge |
| byte_done_i | input | 1 | One-cycle strobe when a byte (including acknowledge) completes |
| addr_phase_i | input | 1 | High while the slave-address byte is on the bus |
| clr_i | input | 1 | Clears the lost flag |
| lost_o | output | 1 | Sticky arbitration-lost flag |
| mst_o | output | 1 | Master-mode bit |
| xmt_o | output | 1 | Transmit-mode bit |
| addr_watch_o | output | 1 | Lost during the address byte; compare own address |

## Verification
A wrong internal state shows up at the ports one cycle after the SCL edge or strobe that caused it. A missed or spurious detection appears on lost_o and xmt_o immediately. A bad pending-drop state is only visible at the next byte_done_i, when mst_o either falls when it should not or stays high when it should fall. The sweep covers every intended byte with interference at each bit position, and also with no interference. It checks all four outputs after every bit and after the byte ends, so a flaw becomes visible within at most nine cycles of the event that caused it.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef struct packed {
        logic lost;
        logic mst;
        logic xmt;
        logic pend;
        logic awatch;
    } arb_state_t;

    localparam arb_state_t ARB_RESET = '{lost: 1'b0, mst: 1'b0, xmt: 1'b0,
                                         pend: 1'b0, awatch: 1'b0};
endpackage

// File: rtl/arb_loss_cmp.sv
module arb_loss_cmp (
    input  logic scl_rise,
    input  logic mst,
    input  logic xmt,
    input  logic want_sda,
    input  logic sda,
    output logic hit
);
    logic armed;

    // only a master transmitter can lose; only released bits are compared
    always_comb begin
        armed = scl_rise & mst & xmt;
        hit   = armed & want_sda & ~sda;
    end
endmodule

// File: rtl/arb_mode_seq.sv
module arb_mode_seq
    import arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  logic       addr_phase,
    input  logic       byte_done,
    input  logic       clr,
    input  logic       mode_ld,
    input  logic       mst_in,
    input  logic       xmt_in,
    output arb_state_t state_q
);
    arb_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (hit) begin
            state_d.lost   = 1'b1;
            state_d.xmt    = 1'b0;
            state_d.pend   = 1'b1;
            state_d.awatch = addr_phase;
        end else if (clr) begin
            state_d.lost = 1'b0;
        end
        if (byte_done) begin
            if (state_q.pend || hit) begin
                state_d.mst = 1'b0;
            end
            state_d.pend   = 1'b0;
            state_d.awatch = 1'b0;
        end
        if (mode_ld) begin
            state_d.mst  = mst_in;
            state_d.xmt  = xmt_in;
            state_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_RESET;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/i2c_arb_loss_det.sv
module i2c_arb_loss_det
    import arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_ld_i,
    input  logic mst_in_i,
    input  logic xmt_in_i,
    input  logic want_sda_i,
    input  logic sda_i,
    input  logic scl_rise_i,
    input  logic byte_done_i,
    input  logic addr_phase_i,
    input  logic clr_i,
    output logic lost_o,
    output logic mst_o,
    output logic xmt_o,
    output logic addr_watch_o
);
    arb_state_t st_q;
    logic       hit;

    arb_loss_cmp u_cmp (
        .scl_rise (scl_rise_i),
        .mst      (st_q.mst),
        .xmt      (st_q.xmt),
        .want_sda (want_sda_i),
        .sda      (sda_i),
        .hit      (hit)
    );

    arb_mode_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .addr_phase (addr_phase_i),
        .byte_done  (byte_done_i),
        .clr        (clr_i),
        .mode_ld    (mode_ld_i),
        .mst_in     (mst_in_i),
        .xmt_in     (xmt_in_i),
        .state_q    (st_q)
    );

    assign lost_o       = st_q.lost;
    assign mst_o        = st_q.mst;
    assign xmt_o        = st_q.xmt;
    assign addr_watch_o = st_q.awatch;
endmodule

module arb_loss_chk (
    input logic clk,
    input logic rst_n,
    input logic mode_ld_i,
    input logic want_sda_i,
    input logic sda_i,
    input logic scl_rise_i,
    input logic byte_done_i,
    input logic clr_i,
    input logic lost_o,
    input logic mst_o,
    input logic xmt_o,
    input logic addr_watch_o
);
    logic det;
    assign det = scl_rise_i & mst_o & xmt_o & want_sda_i & ~sda_i;

    // R3
    loss_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        det |=> lost_o);

    // R3
    loss_drops_xmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (det && !mode_ld_i) |=> !xmt_o);

    // R4
    lost_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost_o) |-> $past(det));

    // R8
    lost_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_o && !clr_i) |=> lost_o);

    // R6
    mst_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mst_o) |-> $past(byte_done_i || mode_ld_i));

    // R9
    awatch_needs_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_watch_o) |-> lost_o);
endmodule

bind i2c_arb_loss_det arb_loss_chk u_arb_loss_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_ld_i    (mode_ld_i),
    .want_sda_i   (want_sda_i),
    .sda_i        (sda_i),
    .scl_rise_i   (scl_rise_i),
    .byte_done_i  (byte_done_i),
    .clr_i        (clr_i),
    .lost_o       (lost_o),
    .mst_o        (mst_o),
    .xmt_o        (xmt_o),
    .addr_watch_o (addr_watch_o)
);

// File: tb/test_i2c_arb_loss_det.sv
module test_i2c_arb_loss_det;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_ld_i = 0, mst_in_i = 0, xmt_in_i = 0, want_sda_i = 0, sda_i = 1;
    logic scl_rise_i = 0, byte_done_i = 0, addr_phase_i = 0, clr_i = 0;
    logic lost_o, mst_o, xmt_o, addr_watch_o;
    int   checks = 0;
    int   errors = 0;

    always #4 clk = ~clk;

    i2c_arb_loss_det i_i2c_arb_loss_det (.*);

    task automatic chk(input logic got, input logic exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0b expected %0b", what, got, exp);
        end
    endtask

    task automatic idle();
        mode_ld_i = 0; scl_rise_i = 0; byte_done_i = 0; clr_i = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic load(input logic m, input logic x);
        mode_ld_i = 1; mst_in_i = m; xmt_in_i = x; clr_i = 1;
        tick();
    endtask

    task automatic bit_cyc(input logic w, input logic s);
        scl_rise_i = 1; want_sda_i = w; sda_i = s;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk(lost_o, 0, "R1 lost"); chk(mst_o, 0, "R1 mst");
        chk(xmt_o, 0, "R1 xmt"); chk(addr_watch_o, 0, "R1 awatch");
        rst_n = 1;
        @(negedge clk);

        // R5: no detection without master+transmit or without edge
        load(1, 0); chk(mst_o, 1, "R2 mst"); chk(xmt_o, 0, "R2 xmt");
        bit_cyc(1, 0); chk(lost_o, 0, "R5 mst only");
        load(0, 1); bit_cyc(1, 0); chk(lost_o, 0, "R5 xmt only");
        load(1, 1); want_sda_i = 1; sda_i = 0; tick();
        chk(lost_o, 0, "R5 no scl edge");
        // R7: byte end without loss keeps master
        byte_done_i = 1; tick(); chk(mst_o, 1, "R7 mst kept");

        // R8: sticky flag, clear, set wins over clear
        bit_cyc(1, 0); chk(lost_o, 1, "R3 lost");
        repeat (3) tick(); chk(lost_o, 1, "R8 sticky");
        clr_i = 1; tick(); chk(lost_o, 0, "R8 clear");
        load(1, 1); scl_rise_i = 1; want_sda_i = 1; sda_i = 0;
        clr_i = 1; tick(); chk(lost_o, 1, "R8 set wins");

        // R6: byte_done in the detecting cycle
        load(1, 1); scl_rise_i = 1; want_sda_i = 1; sda_i = 0;
        byte_done_i = 1; tick();
        chk(mst_o, 0, "R6 same-cycle drop"); chk(xmt_o, 0, "R6 xmt");

        // R10: load coinciding with detection
        load(1, 1); scl_rise_i = 1; want_sda_i = 1; sda_i = 0;
        mode_ld_i = 1; mst_in_i = 1; xmt_in_i = 1; tick();
        chk(lost_o, 1, "R10 lost"); chk(xmt_o, 1, "R10 xmt loaded");
        byte_done_i = 1; tick(); chk(mst_o, 1, "R10 drop cancelled");

        // sweep: every intended byte, interference at each bit or none
        for (int w = 0; w < 256; w++) begin
            for (int p = 0; p < 9; p++) begin
                logic lm, am, ap;
                lm = 0; am = 0; ap = logic'((w + p) & 1);
                load(1, 1);
                chk(lost_o, 0, "R8 cleared"); chk(mst_o, 1, "R2 mst");
                chk(xmt_o, 1, "R2 xmt");
                addr_phase_i = ap;
                for (int b = 7; b >= 0; b--) begin
                    logic wb, ln;
                    wb = logic'((w >> b) & 1);
                    ln = wb & ((p == b) ? 1'b0 : 1'b1);
                    if (!lm && wb && !ln) begin
                        lm = 1; am = ap;
                    end
                    bit_cyc(wb, ln);
                    chk(lost_o, lm, "R3/R4 lost per bit");
                    chk(xmt_o, !lm, "R3 xmt per bit");
                    chk(mst_o, 1, "R6 mst held in byte");
                    chk(addr_watch_o, am, "R9 awatch");
                end
                byte_done_i = 1; tick();
                chk(mst_o, !lm, "R6 mst after byte");
                chk(addr_watch_o, 0, "R9 awatch cleared");
                chk(lost_o, lm, "R8 lost after byte");
                addr_phase_i = 0;
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule